// File: doc/BRIEF.md
# Cascadable Start-Pulse Channel Loader

This block fills a line of 384 six-bit channel codes from a stream of 18-bit pixel words. Each word carries three codes. One word is taken per clock, so a full line takes 128 clocks. Loading is armed by a start pulse on one of two bidirectional pins. After the last word the block drops into standby on its own and ignores further pixel words until a new start pulse rises. One clock before that last word, the block drives a one-clock start pulse out of the other pin. The next device in a chain, which shares the same pixel bus, then takes the word that follows.

A direction input sets the fill order (channel 1 upward or channel 384 downward) and which pin listens and which pin drives. A separate latch strobe controls the output side. Its rising edge aborts any load in progress. Its falling edge copies the whole line into an output register, together with a per-channel reference-bank select derived from the polarity input. All inputs are sampled on the rising edge of the single clock.

Top module: `cascade_line_loader`

## Requirements
- R1: After reset, every output code is 0, every bank-select bit is 0, the block is in standby, and the active start-output pin reads 0.
- R2: A start pulse rise sampled at edge k arms loading; the pixel words present at edges k+1 through k+128 are captured, one word per edge; 18-bit word bits [5:0], [11:6], [17:12] form lanes 0, 1, 2.
- R3: With `scan_fwd`=1, `start_a` is the start input and `start_b` the start output, and the word captured at edge k+1+p loads lane j into channel index 3p+j (index 0 is channel 1).
- R4: With `scan_fwd`=0, `start_b` is the start input and `start_a` the start output, and the word captured at edge k+1+p loads lane j into channel index 383-3p-j.
- R5: After the 128th capture the block stays in standby; pixel words presented afterwards change no channel until the next start rise.
- R6: A start pulse held high for one or for two sampled edges starts exactly one load, and in both cases the first word is the one at edge k+1.
- R7: The start output is 1 only between edges k+127 and k+128, so the next device samples it at edge k+128 and loads from k+129; at all other times it is 0, and the pin acting as input is never driven by the block.
- R8: A sampled rise of `latch_strobe` ends any load at once: the word at that edge and later words are not captured, and no start-output pulse is produced.
- R9: On a sampled fall of `latch_strobe` the output codes take the current line contents; at every other edge they hold.
- R10: At that same fall `polarity` is captured: bank bit i is 1 (high bank) when i is even and polarity is 1, or when i is odd and polarity is 0; later polarity changes do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| scan_fwd | input | 1 | 1: upward fill, start in on start_a; 0: downward, start in on start_b |
| start_a | inout | 1 | Start input when scan_fwd=1, start output otherwise |
| start_b | inout | 1 | Start output when scan_fwd=1, start input otherwise |
| pix_data | input | 18 | Three 6-bit channel codes, lane 0 in the low bits |
| latch_strobe | input | 1 | Rise aborts loading, fall transfers the line to the outputs |
| polarity | input | 1 | Bank assignment, captured on the strobe fall |
| chan_codes | output | 2304 | Output codes, channel index i at bits [6i+5:6i] |
| bank_high | output | 384 | Per-channel bank select, 1 = high reference bank |

## Verification
The assertions take for granted that `scan_fwd` is steady from the start pulse to the end of the load. They also assume the start pulse lasts at most two clocks. The latch strobe is taken to stay high for at least five clocks and to rise no sooner than two clocks after the last captured word. The stimulus changes every input only on falling clock edges, switches direction only in standby, and releases the pin that the block drives. Its strobe pulses meet these width and spacing limits, except in the abort case, where the strobe is raised on purpose in the middle of a load.

// File: rtl/cll_pkg.sv
package cll_pkg;
    localparam int CODE_W = 6;
    localparam int LANES  = 3;
    localparam int PIX_W  = CODE_W * LANES;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t lane2;
        code_t lane1;
        code_t lane0;
    } pixel_t;

    function automatic code_t lane_of(input pixel_t px, input int idx);
        case (idx)
            0:       return px.lane0;
            1:       return px.lane1;
            default: return px.lane2;
        endcase
    endfunction
endpackage

// File: rtl/cll_pointer.sv
module cll_pointer #(
    parameter int NUM_STAGES = 128,
    localparam int PTR_W     = $clog2(NUM_STAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_in,
    input  logic             strobe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_pos,
    output logic             start_pulse
);
    localparam logic [PTR_W-1:0] LAST_POS = PTR_W'(NUM_STAGES - 1);
    localparam logic [PTR_W-1:0] PRE_LAST = PTR_W'(NUM_STAGES - 2);

    logic start_q, strobe_q, busy;
    logic [PTR_W-1:0] cnt;
    logic start_rise, strobe_rise;

    assign start_rise  = start_in & ~start_q;
    assign strobe_rise = strobe & ~strobe_q;
    assign wr_en       = busy & ~strobe_rise & ~start_rise;
    assign wr_pos      = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q     <= 1'b0;
            strobe_q    <= 1'b0;
            busy        <= 1'b0;
            cnt         <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_q     <= start_in;
            strobe_q    <= strobe;
            start_pulse <= 1'b0;
            if (strobe_rise) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (start_rise) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                start_pulse <= (cnt == PRE_LAST);
                if (cnt == LAST_POS) busy <= 1'b0;
                else                 cnt  <= cnt + 1'b1;
            end
        end
    end

    // R7: the hand-off pulse lasts exactly one clock
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);
    // R8: a strobe rise leaves the pointer idle
    a_r8_strobe_stops: assert property (@(posedge clk) disable iff (rst)
        strobe_rise |=> !busy);
    // R5: after the final stage the block drops to standby
    a_r5_end_standby: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == LAST_POS && !strobe_rise && !start_rise) |=> !busy);
    // R2: a start rise arms loading at stage position zero
    a_r2_arm: assert property (@(posedge clk) disable iff (rst)
        (start_rise && !strobe_rise) |=> (busy && cnt == '0));
endmodule

// File: rtl/cll_line_store.sv
module cll_line_store import cll_pkg::*; #(
    parameter int NUM_STAGES = 128,
    localparam int PTR_W     = $clog2(NUM_STAGES),
    localparam int NUM_CH    = NUM_STAGES * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_pos,
    input  logic             fwd,
    input  pixel_t           pix,
    output code_t            line [NUM_CH]
);
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        code_t slot [LANES];
        logic  hit;

        assign hit = wr_en && (fwd ? (wr_pos == PTR_W'(s))
                                   : (wr_pos == PTR_W'(NUM_STAGES - 1 - s)));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int j = 0; j < LANES; j++) slot[j] <= '0;
            end else if (hit) begin
                for (int j = 0; j < LANES; j++)
                    slot[j] <= fwd ? lane_of(pix, j) : lane_of(pix, LANES - 1 - j);
            end
        end

        for (genvar j = 0; j < LANES; j++) begin : g_lane
            assign line[s*LANES + j] = slot[j];
        end
    end
endmodule

// File: rtl/cll_out_latch.sv
module cll_out_latch import cll_pkg::*; #(
    parameter int NUM_CH = 384
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     strobe,
    input  logic                     pol,
    input  code_t                    line [NUM_CH],
    output logic [NUM_CH*CODE_W-1:0] codes_out,
    output logic [NUM_CH-1:0]        bank_out
);
    logic strobe_q, xfer;

    assign xfer = ~strobe & strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q  <= 1'b0;
            codes_out <= '0;
            bank_out  <= '0;
        end else begin
            strobe_q <= strobe;
            if (xfer) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    codes_out[i*CODE_W +: CODE_W] <= line[i];
                    bank_out[i] <= (i % 2 == 0) ? pol : ~pol;
                end
            end
        end
    end

    // R9: outputs only move on a strobe fall
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(codes_out));
    // R10: channel 1 bank follows polarity sampled at the fall
    a_r10_pol_capture: assert property (@(posedge clk) disable iff (rst)
        xfer |=> bank_out[0] == $past(pol));
    // R10: neighbouring channels always sit on opposite banks after a transfer
    a_r10_bank_split: assert property (@(posedge clk) disable iff (rst)
        xfer |=> bank_out[0] != bank_out[1]);
endmodule

// File: rtl/cascade_line_loader.sv
module cascade_line_loader import cll_pkg::*; #(
    parameter int NUM_STAGES = 128,
    localparam int PTR_W     = $clog2(NUM_STAGES),
    localparam int NUM_CH    = NUM_STAGES * LANES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scan_fwd,
    inout  wire                      start_a,
    inout  wire                      start_b,
    input  logic [PIX_W-1:0]         pix_data,
    input  logic                     latch_strobe,
    input  logic                     polarity,
    output logic [NUM_CH*CODE_W-1:0] chan_codes,
    output logic [NUM_CH-1:0]        bank_high
);
    logic             start_in, start_pulse, wr_en;
    logic [PTR_W-1:0] wr_pos;
    code_t            line [NUM_CH];

    assign start_in = scan_fwd ? start_a : start_b;
    assign start_a  = scan_fwd ? 1'bz : start_pulse;
    assign start_b  = scan_fwd ? start_pulse : 1'bz;

    cll_pointer #(.NUM_STAGES(NUM_STAGES)) u_pointer (
        .clk(clk), .rst(rst), .start_in(start_in), .strobe(latch_strobe),
        .wr_en(wr_en), .wr_pos(wr_pos), .start_pulse(start_pulse)
    );

    cll_line_store #(.NUM_STAGES(NUM_STAGES)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pos(wr_pos),
        .fwd(scan_fwd), .pix(pixel_t'(pix_data)), .line(line)
    );

    cll_out_latch #(.NUM_CH(NUM_CH)) u_out (
        .clk(clk), .rst(rst), .strobe(latch_strobe), .pol(polarity),
        .line(line), .codes_out(chan_codes), .bank_out(bank_high)
    );
endmodule

// File: tb/test_cascade_line_loader.sv
module test_cascade_line_loader;
    localparam int NCH = 384;
    localparam int NST = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_fwd = 1'b1;
    logic drv_a = 1'b0, drv_b = 1'b0, en_a = 1'b1, en_b = 1'b0;
    logic [17:0] pix_data = '0;
    logic latch_strobe = 1'b0;
    logic polarity = 1'b0;
    logic [NCH*6-1:0] chan_codes;
    logic [NCH-1:0] bank_high;
    wire start_a, start_b;

    assign start_a = en_a ? drv_a : 1'bz;
    assign start_b = en_b ? drv_b : 1'bz;

    cascade_line_loader i_cascade_line_loader (
        .clk(clk), .rst(rst), .scan_fwd(scan_fwd), .start_a(start_a),
        .start_b(start_b), .pix_data(pix_data), .latch_strobe(latch_strobe),
        .polarity(polarity), .chan_codes(chan_codes), .bank_high(bank_high)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [5:0] exp_line [NCH];
    logic [5:0] exp_out  [NCH];
    logic [NCH-1:0] exp_bank = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] code_of(int seed, int p, int k);
        return 6'((seed * 7 + p * 3 + k) & 63);
    endfunction

    function automatic logic [17:0] word_of(int seed, int p);
        return {code_of(seed, p, 2), code_of(seed, p, 1), code_of(seed, p, 0)};
    endfunction

    function automatic logic out_pin();
        return scan_fwd ? start_b : start_a;
    endfunction

    task automatic set_dir(input bit fwd);
        @(negedge clk);
        scan_fwd = fwd; en_a = fwd; en_b = !fwd; drv_a = 1'b0; drv_b = 1'b0;
    endtask

    task automatic set_start(input logic v);
        if (scan_fwd) drv_a = v; else drv_b = v;
    endtask

    task automatic check_codes(input string req, input string what);
        int bad = 0, first = -1;
        for (int i = 0; i < NCH; i++)
            if (chan_codes[i*6 +: 6] !== exp_out[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, {what, " channel index shown as actual, code as expected"},
                   first, exp_out[first]);
    endtask

    task automatic test_reset();
        for (int i = 0; i < NCH; i++) begin exp_line[i] = '0; exp_out[i] = '0; end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_codes("R1", "codes after reset");
        check(bank_high == '0, "R1", "bank after reset", longint'(bank_high[63:0]), 0);
        check(out_pin() == 1'b0, "R1", "start output after reset", out_pin(), 0);
    endtask

    // Loads one line; stop_at < 128 raises the strobe at that word (R8 abort)
    task automatic load_line(input bit fwd, input int seed, input int width,
                             input int stop_at);
        int ch;
        set_dir(fwd);
        @(negedge clk);
        set_start(1'b1);
        @(negedge clk);
        if (width == 1) set_start(1'b0);
        for (int p = 0; p < NST; p++) begin
            if (p == 1) set_start(1'b0);
            if (p == stop_at) begin
                latch_strobe = 1'b1;
                for (int q = 0; q < 6; q++) begin
                    pix_data = word_of(seed + 1, p + q);
                    @(negedge clk);
                    check(out_pin() == 1'b0, "R8", "no hand-off after abort", out_pin(), 0);
                end
                return;
            end
            check(out_pin() == (p == NST - 1), "R7", $sformatf("start out before word %0d", p),
                  out_pin(), (p == NST - 1));
            pix_data = word_of(seed, p);
            for (int k = 0; k < 3; k++) begin
                ch = fwd ? 3 * p + k : NCH - 1 - 3 * p - k;
                exp_line[ch] = code_of(seed, p, k);
            end
            @(negedge clk);
        end
        check(out_pin() == 1'b0, "R7", "start out after last word", out_pin(), 0);
        check_codes("R9", "outputs hold during load");
    endtask

    task automatic latch_line(input logic pol, input string req);
        latch_strobe = 1'b1;
        polarity = pol;
        repeat (5) @(negedge clk);
        check_codes("R9", "outputs hold while strobe high");
        latch_strobe = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            exp_out[i] = exp_line[i];
            exp_bank[i] = (i % 2 == 0) ? pol : !pol;
        end
        check_codes(req, "line after strobe fall");
        check(bank_high == exp_bank, "R10", "bank select", longint'(bank_high[63:0]),
              longint'(exp_bank[63:0]));
        polarity = !pol;
        repeat (2) @(negedge clk);
        check(bank_high == exp_bank, "R10", "bank held after polarity change",
              longint'(bank_high[63:0]), longint'(exp_bank[63:0]));
    endtask

    task automatic test_forward();
        load_line(1'b1, 1, 1, NST);
        @(negedge clk);
        latch_line(1'b1, "R3");
    endtask

    task automatic test_standby();
        load_line(1'b1, 5, 1, NST);
        for (int q = 0; q < 20; q++) begin
            pix_data = word_of(40, q);
            @(negedge clk);
        end
        latch_line(1'b0, "R5");
    endtask

    task automatic test_reverse_wide();
        load_line(1'b0, 9, 2, NST);
        @(negedge clk);
        latch_line(1'b1, "R4");
        check(exp_out[383] == code_of(9, 0, 0), "R6", "two-clock start first word",
              exp_out[383], code_of(9, 0, 0));
    endtask

    task automatic test_abort();
        load_line(1'b1, 13, 1, 10);
        latch_line(1'b0, "R8");
    endtask

    initial begin
        test_reset();
        test_forward();
        test_standby();
        test_reverse_wide();
        test_abort();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule